// File: doc/BRIEF.md
# SIMD Saturating Narrow Unit

The unit converts a 64-bit vector of wide integer lanes into a 32-bit vector of lanes half as wide. An element-size select picks 16-to-8 (four lanes), 32-to-16 (two lanes) or 64-to-32 (one lane). A mode select picks how each lane is reduced. It can simply drop the upper half. It can also clamp to the narrow signed range, to the narrow unsigned range, or from a signed source into the narrow unsigned range.

The unit accepts one operation per clock, marked by a valid strobe. It returns the packed result and an output valid one cycle later. Any lane that clamps sets a sticky saturation flag. The flag is shared by all lanes and all operations, so a sequence of narrows can be checked for overflow once at the end. A clear pulse resets the flag. An unused size code is reported as an error and gives a zero result.

Top module: `simd_narrow_sat`

## Requirements
- R1: Source lane i (bits starting at i*2W) lands in result bits starting at i*W, with lane 0 least significant. Size code 0 gives four 8-bit lanes, code 1 gives two 16-bit lanes and code 2 gives one 32-bit lane.
- R2: Mode code 0 (truncate) returns the low W bits of every lane.
- R3: Mode code 1 (signed to signed) passes a lane that fits the W-bit signed range. Otherwise it returns the most negative W-bit value for a negative lane and the most positive value for a positive one, and the lane counts as saturated.
- R4: Mode code 2 (unsigned to unsigned) returns all ones for a lane above 2^W-1, and the lane counts as saturated. Any other lane passes unchanged.
- R5: Mode code 3 (signed to unsigned) returns zero for a lane with its top bit set and all ones for a non-negative lane above 2^W-1, and both count as saturated. Any other lane passes unchanged.
- R6: A truncate operation never sets the saturation flag.
- R7: The saturation flag is sticky. It becomes set in the cycle after a valid operation with at least one saturated lane. It then stays set until a clear or reset.
- R8: `qc_clear` zeroes the flag on the next edge. A saturation accepted in the same cycle as the clear still leaves the flag set.
- R9: Size code 3 is illegal. It gives `out_err`=1 with `out_data`=0 and leaves the flag unchanged.
- R10: The result, error and valid appear one cycle after `in_valid`. When `in_valid` is low, `out_valid` drops and `out_data`/`out_err` hold their values.
- R11: During reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_src | input | 64 | Wide source vector |
| in_size | input | 2 | Element size code (0: 16-to-8, 1: 32-to-16, 2: 64-to-32, 3: illegal) |
| in_mode | input | 2 | Narrow mode (0 truncate, 1 signed, 2 unsigned, 3 signed-to-unsigned) |
| qc_clear | input | 1 | Clears the saturation flag |
| out_valid | output | 1 | Result valid |
| out_data | output | 32 | Packed narrow result |
| out_err | output | 1 | Illegal size reported |
| out_qc | output | 1 | Sticky saturation flag |

## Verification
Every output is due exactly one clock edge after the cycle that drives it: the result, error and valid after the strobe, and the flag after a saturating operation or a clear. The bench drives a new input set on each falling edge. It compares the outputs seen at that falling edge with a model state that was advanced by the previous input set, so the comparison always lands one edge after its stimulus. Hold behaviour is covered the same way: the model keeps its old data on idle cycles, and the comparison continues on those cycles.

// File: rtl/narrow_pkg.sv
`timescale 1ns/1ps
package narrow_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } elem_sz_e;

  typedef enum logic [1:0] {
    MD_TRUNC = 2'b00,
    MD_SSAT  = 2'b01,
    MD_USAT  = 2'b10,
    MD_S2U   = 2'b11
  } nmode_e;
endpackage

// File: rtl/narrow_lane.sv
`timescale 1ns/1ps
module narrow_lane
  import narrow_pkg::*;
#(
  parameter int NW = 8
) (
  input  logic [2*NW-1:0] wide_i,
  input  nmode_e          mode_i,
  output logic [NW-1:0]   nar_o,
  output logic            sat_o
);
  localparam logic [NW-1:0] ONES = {NW{1'b1}};
  localparam logic [NW-1:0] SMAX = {1'b0, {(NW-1){1'b1}}};
  localparam logic [NW-1:0] SMIN = {1'b1, {(NW-1){1'b0}}};

  logic          neg;
  logic [NW:0]   top_s;
  logic [NW-1:0] top_u;
  logic          s_fit;

  assign neg   = wide_i[2*NW-1];
  assign top_s = wide_i[2*NW-1:NW-1];
  assign top_u = wide_i[2*NW-1:NW];
  assign s_fit = (top_s == '0) || (top_s == '1);

  always_comb begin
    nar_o = wide_i[NW-1:0];
    sat_o = 1'b0;
    unique case (mode_i)
      MD_TRUNC: begin
        nar_o = wide_i[NW-1:0];
      end
      MD_SSAT: begin
        if (!s_fit) begin
          nar_o = neg ? SMIN : SMAX;
          sat_o = 1'b1;
        end
      end
      MD_USAT: begin
        if (|top_u) begin
          nar_o = ONES;
          sat_o = 1'b1;
        end
      end
      MD_S2U: begin
        if (neg) begin
          nar_o = '0;
          sat_o = 1'b1;
        end else if (|top_u[NW-2:0]) begin
          nar_o = ONES;
          sat_o = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/narrow_stage.sv
`timescale 1ns/1ps
module narrow_stage
  import narrow_pkg::*;
#(
  parameter int NW    = 8,
  parameter int LANES = 4
) (
  input  logic [2*NW*LANES-1:0] src_i,
  input  nmode_e                mode_i,
  output logic [NW*LANES-1:0]   res_o,
  output logic                  sat_o
);
  logic [LANES-1:0] lane_sat;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    narrow_lane #(.NW(NW)) u_lane (
      .wide_i (src_i[i*2*NW +: 2*NW]),
      .mode_i (mode_i),
      .nar_o  (res_o[i*NW +: NW]),
      .sat_o  (lane_sat[i])
    );
  end

  assign sat_o = |lane_sat;
endmodule

// File: rtl/simd_narrow_sat.sv
`timescale 1ns/1ps
module simd_narrow_sat
  import narrow_pkg::*;
#(
  parameter int SRC_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SRC_W-1:0] in_src,
  input  logic [1:0]       in_size,
  input  logic [1:0]       in_mode,
  input  logic             qc_clear,
  output logic             out_valid,
  output logic [SRC_W/2-1:0] out_data,
  output logic             out_err,
  output logic             out_qc
);
  localparam int DST_W = SRC_W / 2;
  localparam int NSZ   = 3;
  localparam int MIN_W = DST_W >> (NSZ - 1);

  logic [DST_W-1:0] stage_res [NSZ];
  logic [NSZ-1:0]   stage_sat;
  nmode_e           mode;

  assign mode = nmode_e'(in_mode);

  for (genvar k = 0; k < NSZ; k++) begin : g_size
    localparam int NW = MIN_W << k;
    narrow_stage #(.NW(NW), .LANES(DST_W / NW)) u_stage (
      .src_i  (in_src),
      .mode_i (mode),
      .res_o  (stage_res[k]),
      .sat_o  (stage_sat[k])
    );
  end

  logic             legal;
  logic [DST_W-1:0] sel_res;
  logic             sel_sat;

  always_comb begin
    legal   = 1'b1;
    sel_res = '0;
    sel_sat = 1'b0;
    unique case (elem_sz_e'(in_size))
      SZ_BYTE: begin sel_res = stage_res[0]; sel_sat = stage_sat[0]; end
      SZ_HALF: begin sel_res = stage_res[1]; sel_sat = stage_sat[1]; end
      SZ_WORD: begin sel_res = stage_res[2]; sel_sat = stage_sat[2]; end
      default: legal = 1'b0;
    endcase
  end

  logic             vld_q, vld_d;
  logic [DST_W-1:0] data_q, data_d;
  logic             err_q, err_d;
  logic             qc_q, qc_d;
  logic             res_en;

  assign res_en = in_valid;

  always_comb begin
    vld_d  = in_valid;
    data_d = legal ? sel_res : '0;
    err_d  = ~legal;
    qc_d   = (qc_clear ? 1'b0 : qc_q) | (in_valid & legal & sel_sat);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      err_q  <= 1'b0;
      qc_q   <= 1'b0;
    end else begin
      vld_q <= vld_d;
      qc_q  <= qc_d;
      if (res_en) begin
        data_q <= data_d;
        err_q  <= err_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;
  assign out_err   = err_q;
  assign out_qc    = qc_q;
endmodule

// File: rtl/simd_narrow_sat_chk.sv
`timescale 1ns/1ps
module simd_narrow_sat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  in_size,
  input logic [1:0]  in_mode,
  input logic        qc_clear,
  input logic        out_valid,
  input logic [31:0] out_data,
  input logic        out_err,
  input logic        out_qc
);
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r10_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data) && $stable(out_err));
  a_r9_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_data == 32'd0);
  a_r9_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_size == 2'b11 && !qc_clear) |=> out_err && (out_qc == $past(out_qc)));
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (out_qc && !qc_clear) |=> out_qc);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (qc_clear && !in_valid) |=> !out_qc);
  a_r6_trunc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b00 && !out_qc) |=> !out_qc);
endmodule

bind simd_narrow_sat simd_narrow_sat_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_size   (in_size),
  .in_mode   (in_mode),
  .qc_clear  (qc_clear),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_err   (out_err),
  .out_qc    (out_qc)
);

// File: tb/simd_narrow_sat_test.sv
`timescale 1ns/1ps
module simd_narrow_sat_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_src;
  logic [1:0]  in_size;
  logic [1:0]  in_mode;
  logic        qc_clear;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_err;
  logic        out_qc;

  always #2 clk = ~clk;

  simd_narrow_sat uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src(in_src),
    .in_size(in_size), .in_mode(in_mode), .qc_clear(qc_clear),
    .out_valid(out_valid), .out_data(out_data), .out_err(out_err),
    .out_qc(out_qc)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  bit    e_valid, e_err, e_qc;
  logic [31:0] e_data;
  string e_tag;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void ref_narrow(input logic [63:0] src, input logic [1:0] sz,
                                     input logic [1:0] md, output logic [31:0] res,
                                     output bit sat, output bit bad);
    res = '0; sat = 0; bad = 0;
    if (sz == 2'd3) begin
      bad = 1;
      return;
    end
    for (int lane = 0; lane < (4 >> sz); lane++) begin
      int nw;
      logic signed [127:0] w, v, n, umax, smax, smin;
      nw   = 8 << sz;
      umax = (128'sd1 <<< nw) - 1;
      smax = (128'sd1 <<< (nw - 1)) - 1;
      smin = -(128'sd1 <<< (nw - 1));
      w = $signed({64'd0, src}) >>> (lane * 2 * nw);
      w = w & ((128'sd1 <<< (2 * nw)) - 1);
      v = w;
      if (w[2*nw-1]) v = w - (128'sd1 <<< (2 * nw));
      case (md)
        2'd0: n = w & umax;
        2'd1: begin
          if (v > smax) begin n = smax; sat = 1; end
          else if (v < smin) begin n = smin & umax; sat = 1; end
          else n = v & umax;
        end
        2'd2: begin
          if (w > umax) begin n = umax; sat = 1; end
          else n = w;
        end
        default: begin
          if (v < 0) begin n = 0; sat = 1; end
          else if (v > umax) begin n = umax; sat = 1; end
          else n = v;
        end
      endcase
      res = res | (n[31:0] << (lane * nw));
    end
  endfunction

  // compare outputs due now, then drive next inputs and advance the model
  task automatic step(input logic [63:0] src, input logic [1:0] sz, input logic [1:0] md,
                      input bit v, input bit clr);
    logic [31:0] r;
    bit s, b;
    @(negedge clk);
    chk("R10 valid", {63'd0, out_valid}, {63'd0, e_valid});
    chk(e_tag, {32'd0, out_data}, {32'd0, e_data});
    chk("R9 err", {63'd0, out_err}, {63'd0, e_err});
    chk("R6,R7,R8 flag", {63'd0, out_qc}, {63'd0, e_qc});
    in_src = src; in_size = sz; in_mode = md; in_valid = v; qc_clear = clr;
    ref_narrow(src, sz, md, r, s, b);
    e_valid = v;
    if (v) begin
      e_data = b ? 32'd0 : r;
      e_err  = b;
      if (b) e_tag = "R9 data";
      else case (md)
        2'd0: e_tag = "R1,R2 data";
        2'd1: e_tag = "R1,R3 data";
        2'd2: e_tag = "R1,R4 data";
        default: e_tag = "R1,R5 data";
      endcase
    end else begin
      e_tag = "R10 hold";
    end
    e_qc = (clr ? 1'b0 : e_qc) | (v & !b & s);
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_src = '0; in_size = '0; in_mode = '0; qc_clear = 0;
    e_valid = 0; e_err = 0; e_qc = 0; e_data = '0; e_tag = "R10 hold";
    repeat (3) @(negedge clk);
    chk("R11 reset valid", {63'd0, out_valid}, 64'd0);
    chk("R11 reset data", {32'd0, out_data}, 64'd0);
    chk("R11 reset err", {63'd0, out_err}, 64'd0);
    chk("R11 reset flag", {63'd0, out_qc}, 64'd0);
    rst_n = 1;
    // R2 truncate at each size, R6 flag stays clear
    step(64'h1234_5678_9ABC_DEF0, 2'd0, 2'd0, 1, 0);
    step(64'hFFFF_8000_7FFF_0001, 2'd1, 2'd0, 1, 0);
    step(64'hDEAD_BEEF_0000_0005, 2'd2, 2'd0, 1, 0);
    // R3 signed boundaries
    step(64'h007F_0080_FF80_FF7F, 2'd0, 2'd1, 1, 0);
    step(64'h0, 2'd0, 2'd0, 0, 1);
    step(64'h0000_7FFF_FFFF_8000, 2'd1, 2'd1, 1, 0);
    step(64'hFFFF_FFFF_8000_0000, 2'd2, 2'd1, 1, 1);
    step(64'hFFFF_FFFF_7FFF_FFFF, 2'd2, 2'd1, 1, 1);
    // R4 unsigned
    step(64'h0100_00FF_FFFF_0000, 2'd0, 2'd2, 1, 1);
    step(64'h0000_FFFF_0001_0000, 2'd1, 2'd2, 1, 1);
    step(64'h0000_0000_FFFF_FFFF, 2'd2, 2'd2, 1, 1);
    step(64'h0000_0001_0000_0000, 2'd2, 2'd2, 1, 1);
    // R5 signed to unsigned
    step(64'h8000_00FF_0100_7FFF, 2'd0, 2'd3, 1, 1);
    step(64'hFFFF_FFFF_0000_FFFF, 2'd1, 2'd3, 1, 1);
    step(64'h7FFF_FFFF_FFFF_FFFF, 2'd2, 2'd3, 1, 1);
    step(64'h0000_0000_1234_5678, 2'd2, 2'd3, 1, 1);
    // R10 hold on idle, R7 sticky over in-range ops
    step(64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 2'd2, 1, 0);
    step(64'h0, 2'd0, 2'd0, 0, 0);
    step(64'h0000_0000_0000_0001, 2'd1, 2'd1, 1, 0);
    step(64'h0, 2'd0, 2'd0, 0, 0);
    // R9 illegal size with flag set, then with flag clear
    step(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 2'd1, 1, 0);
    step(64'h0, 2'd0, 2'd0, 0, 1);
    step(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 2'd2, 1, 0);
    // R8 clear together with a saturating op
    step(64'h0200_0000_0000_0000, 2'd0, 2'd2, 1, 1);
    step(64'h0, 2'd0, 2'd0, 0, 1);
    step(64'h0, 2'd0, 2'd0, 0, 0);
    for (int i = 0; i < 600; i++) begin
      logic [63:0] s;
      s = {$urandom, $urandom};
      case ($urandom_range(0, 3))
        0: s = s & 64'h01FF_01FF_01FF_01FF;
        1: s = s | 64'hFF80_FF80_FF80_FF80;
        2: s = s & 64'h0000_0001_FFFF_FFFF;
        default: ;
      endcase
      step(s, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
           ($urandom_range(0, 3) != 0), ($urandom_range(0, 15) == 0));
    end
    step(64'h0, 2'd0, 2'd0, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule